// File: doc/BRIEF.md
# Microwire Serial EEPROM Host Controller

This block is the host side of a three-wire serial EEPROM link with 16-bit words. A client inside the chip supplies an operation code, a word address, write data, a burst length and a one-clock start strobe. The controller then drives chip select, the serial clock and the serial data line to the memory, and samples the memory's data output. When the operation is over it pulses a done flag. Read words come back one at a time on a valid strobe.

The serial clock is derived from the system clock. Each half period lasts a set number of system clocks. Reads may fetch a single word or a sequential burst, and the dummy zero that the memory sends before the first word is dropped. Program and erase operations only start inside the memory once chip select falls, so the controller holds chip select low for a minimum time. It then raises chip select again and polls the data output until the memory reports ready. To finish the poll it clocks in a single 1, which returns the data line to high impedance. If ready never comes within a parameterised number of polls, the operation ends with an error flag.

Top module: `mw_eeprom_host`

## Requirements
- R1: While reset is high and in the first cycle after it falls, mw_cs, mw_sk, mw_di, busy, done, err and rd_valid are all 0.
- R2: Each frame is a 1, then a 2-bit opcode (read 10, write 01, erase 11, special 00), then ADDR_W address bits MSB first; write frames append 16 data bits MSB first. cmd_op codes: 0 read, 1 write, 2 erase, 3 enable, 4 disable, 5 erase all, 6 write all, 7 acts as disable.
- R3: For special frames the two most significant address bits select the operation (11 enable, 00 disable, 10 erase all, 01 write all) and all other address bits are sent as 0; write all carries the 16 data bits.
- R4: mw_sk stays high for exactly SK_HALF clocks and low for at least SK_HALF clocks while toggling. mw_sk is high only while mw_cs is high. mw_di never changes while mw_sk is high. mw_do is sampled at the end of each high half.
- R5: On a read, the sample taken during the last address bit is the dummy zero and is discarded. Then cmd_len+1 words of 16 bits follow, each presented once on rd_data with a one-cycle rd_valid, in the order the memory sends them.
- R6: After every frame, mw_cs stays low for at least CS_LOW_MIN clocks before it rises again.
- R7: After write, erase, erase all or write all, the controller raises mw_cs with mw_sk low and samples mw_do once per 2*SK_HALF clocks (0 busy, 1 ready). On ready it clocks one bit with mw_di=1, lowers mw_cs and leaves err at 0.
- R8: If POLL_MAX polls all read busy, mw_cs is lowered, err is set and done follows. err stays set until the next command is accepted.
- R9: A start strobe while busy is high is ignored.
- R10: done is a one-cycle pulse with busy low in that cycle, and a start strobe in that same cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start strobe |
| cmd_op | input | 3 | Operation code (see R2) |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Data for write and write all |
| cmd_len | input | LEN_W | Burst length minus one for reads |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Ready poll timed out |
| rd_valid | output | 1 | rd_data holds a new word |
| rd_data | output | DATA_W | Received read word |
| mw_cs | output | 1 | Memory chip select |
| mw_sk | output | 1 | Memory serial clock |
| mw_di | output | 1 | Serial data to the memory |
| mw_do | input | 1 | Serial data from the memory |

## Verification
The completion pulse and the acceptance of a new start strobe can land in the same cycle, because busy drops together with done. The bench provokes this by raising the strobe for a read in the very cycle it sees done from a write. It then checks that busy rises on the next cycle and that the read returns the word just programmed. A behavioural memory model in the bench decodes every frame bit by bit, so a wrong opcode, address or data bit shows up as a wrong read-back word.

// File: rtl/mwh_pkg.sv
package mwh_pkg;
  typedef enum logic [2:0] {
    OP_READ    = 3'd0,
    OP_WRITE   = 3'd1,
    OP_ERASE   = 3'd2,
    OP_WEN     = 3'd3,
    OP_WDIS    = 3'd4,
    OP_CLRALL  = 3'd5,
    OP_FILLALL = 3'd6,
    OP_RSVD    = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_TX, S_RX, S_GAP, S_POLL, S_REL
  } st_e;
endpackage

// File: rtl/mwh_tick.sv
// Half-period strobe for the serial clock; restarts whenever run is low.
module mwh_tick #(
  parameter int HALF = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  // R4: half periods never collapse to one clock
  p_tick_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/mwh_frame.sv
// Combinational frame builder: left-aligned bit vector plus its length.
module mwh_frame
  import mwh_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16,
  localparam int FW = 3 + AW + DW,
  localparam int BW = $clog2(FW + 1)
) (
  input  op_e           op,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [FW-1:0] bits,
  output logic [BW-1:0] nbits,
  output logic          is_read,
  output logic          is_prog
);
  logic [1:0]    opc;
  logic [AW-1:0] afield;
  logic          has_data;

  always_comb begin
    afield   = '0;
    opc      = 2'b00;
    has_data = 1'b0;
    is_read  = 1'b0;
    is_prog  = 1'b0;
    case (op)
      OP_READ:    begin opc = 2'b10; afield = addr; is_read = 1'b1; end
      OP_WRITE:   begin opc = 2'b01; afield = addr; has_data = 1'b1; is_prog = 1'b1; end
      OP_ERASE:   begin opc = 2'b11; afield = addr; is_prog = 1'b1; end
      OP_WEN:     afield[AW-1 -: 2] = 2'b11;
      OP_CLRALL:  begin afield[AW-1 -: 2] = 2'b10; is_prog = 1'b1; end
      OP_FILLALL: begin afield[AW-1 -: 2] = 2'b01; has_data = 1'b1; is_prog = 1'b1; end
      default:    afield[AW-1 -: 2] = 2'b00;
    endcase
    bits  = {1'b1, opc, afield, has_data ? wdata : {DW{1'b0}}};
    nbits = has_data ? BW'(FW) : BW'(FW - DW);
  end
endmodule

// File: rtl/mwh_rx.sv
// Deserialiser: drops the first sample after start, then emits DW-bit words.
module mwh_rx #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          bit_en,
  input  logic          bit_val,
  output logic          word_valid,
  output logic [DW-1:0] word
);
  localparam int CW = $clog2(DW);

  logic          skip_q;
  logic [CW-1:0] cnt_q;
  logic [DW-2:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      skip_q     <= 1'b0;
      cnt_q      <= '0;
      sr_q       <= '0;
      word       <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (start) begin
        skip_q <= 1'b1;
        cnt_q  <= '0;
      end else if (bit_en) begin
        if (skip_q) begin
          skip_q <= 1'b0;
        end else begin
          sr_q <= {sr_q[DW-3:0], bit_val};
          if (cnt_q == CW'(DW - 1)) begin
            cnt_q      <= '0;
            word       <= {sr_q, bit_val};
            word_valid <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  // R5: every word is announced exactly once
  p_word_single_r5: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);
endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host
  import mwh_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int LEN_W      = 4,
  parameter int SK_HALF    = 25,    // system clocks per serial clock half, >= 2
  parameter int CS_LOW_MIN = 50,    // system clocks of chip select low after a frame
  parameter int POLL_MAX   = 20000  // ready samples before giving up
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              mw_cs,
  output logic              mw_sk,
  output logic              mw_di,
  input  logic              mw_do
);
  localparam int FW  = 3 + ADDR_W + DATA_W;
  localparam int BW  = $clog2(FW + 1);
  localparam int RXW = $clog2(DATA_W * (2 ** LEN_W) + 1);
  localparam int TW  = $clog2(CS_LOW_MIN + 1);
  localparam int PW  = $clog2(POLL_MAX + 1);
  localparam int LCW = $clog2(CS_LOW_MIN + 2);

  st_e             st;
  logic            cs_q, sk_q, di_q, ph_q;
  logic            busy_q, done_q, err_q;
  logic [FW-1:0]   tx_sr;
  logic [BW-1:0]   bit_left;
  logic [RXW-1:0]  rx_left;
  logic [TW-1:0]   tmr;
  logic [PW-1:0]   pcnt;
  logic [LEN_W-1:0] words_q;
  logic            is_read_q, is_prog_q, then_poll;

  logic [FW-1:0]   fr_bits;
  logic [BW-1:0]   fr_n;
  logic            fr_read, fr_prog;
  logic            tick, run, accept, last_tx_fall, rx_bit;

  assign accept = (st == S_IDLE) && cmd_valid;
  assign run    = (st == S_TX) || (st == S_RX) || (st == S_POLL) || (st == S_REL);
  assign last_tx_fall = (st == S_TX) && tick && ph_q && (bit_left == BW'(1));
  assign rx_bit = tick && ph_q && ((st == S_RX) || (last_tx_fall && is_read_q));

  mwh_frame #(.AW(ADDR_W), .DW(DATA_W)) u_frame (
    .op(op_e'(cmd_op)), .addr(cmd_addr), .wdata(cmd_wdata),
    .bits(fr_bits), .nbits(fr_n), .is_read(fr_read), .is_prog(fr_prog)
  );

  mwh_tick #(.HALF(SK_HALF)) u_tick (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  mwh_rx #(.DW(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .start(accept), .bit_en(rx_bit), .bit_val(mw_do),
    .word_valid(rd_valid), .word(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cs_q      <= 1'b0;
      sk_q      <= 1'b0;
      di_q      <= 1'b0;
      ph_q      <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      tx_sr     <= '0;
      bit_left  <= '0;
      rx_left   <= '0;
      tmr       <= '0;
      pcnt      <= '0;
      words_q   <= '0;
      is_read_q <= 1'b0;
      is_prog_q <= 1'b0;
      then_poll <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          tx_sr     <= fr_bits;
          bit_left  <= fr_n;
          is_read_q <= fr_read;
          is_prog_q <= fr_prog;
          words_q   <= cmd_len;
          cs_q      <= 1'b1;
          sk_q      <= 1'b0;
          ph_q      <= 1'b0;
          di_q      <= fr_bits[FW-1];
          busy_q    <= 1'b1;
          err_q     <= 1'b0;
          st        <= S_TX;
        end
        S_TX: if (tick) begin
          ph_q <= ~ph_q;
          sk_q <= ~ph_q;
          if (ph_q) begin
            if (bit_left == BW'(1)) begin
              di_q <= 1'b0;
              if (is_read_q) begin
                rx_left <= RXW'(DATA_W) * (RXW'(words_q) + RXW'(1));
                st      <= S_RX;
              end else begin
                cs_q      <= 1'b0;
                tmr       <= TW'(CS_LOW_MIN - 1);
                then_poll <= is_prog_q;
                st        <= S_GAP;
              end
            end else begin
              bit_left <= bit_left - 1'b1;
              tx_sr    <= tx_sr << 1;
              di_q     <= tx_sr[FW-2];
            end
          end
        end
        S_RX: if (tick) begin
          ph_q <= ~ph_q;
          sk_q <= ~ph_q;
          if (ph_q) begin
            if (rx_left == RXW'(1)) begin
              cs_q      <= 1'b0;
              tmr       <= TW'(CS_LOW_MIN - 1);
              then_poll <= 1'b0;
              st        <= S_GAP;
            end else begin
              rx_left <= rx_left - 1'b1;
            end
          end
        end
        S_GAP: begin
          if (tmr == '0) begin
            if (then_poll) begin
              cs_q <= 1'b1;
              ph_q <= 1'b0;
              pcnt <= '0;
              st   <= S_POLL;
            end else begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
              st     <= S_IDLE;
            end
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        S_POLL: if (tick) begin
          ph_q <= ~ph_q;
          if (ph_q) begin
            if (mw_do) begin
              di_q <= 1'b1;
              st   <= S_REL;
            end else if (pcnt == PW'(POLL_MAX - 1)) begin
              cs_q      <= 1'b0;
              err_q     <= 1'b1;
              tmr       <= TW'(CS_LOW_MIN - 1);
              then_poll <= 1'b0;
              st        <= S_GAP;
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
        end
        S_REL: if (tick) begin
          ph_q <= ~ph_q;
          sk_q <= ~ph_q;
          if (ph_q) begin
            di_q      <= 1'b0;
            cs_q      <= 1'b0;
            tmr       <= TW'(CS_LOW_MIN - 1);
            then_poll <= 1'b0;
            st        <= S_GAP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mw_cs = cs_q;
  assign mw_sk = sk_q;
  assign mw_di = di_q;
  assign busy  = busy_q;
  assign done  = done_q;
  assign err   = err_q;

  // Checker state: clocks spent with chip select low since it last fell.
  logic [LCW-1:0] cs_lo_cnt;
  logic           seen_hi_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_lo_cnt <= '0;
      seen_hi_q <= 1'b0;
    end else begin
      if (mw_cs) seen_hi_q <= 1'b1;
      if (mw_cs) cs_lo_cnt <= '0;
      else if (cs_lo_cnt != {LCW{1'b1}}) cs_lo_cnt <= cs_lo_cnt + 1'b1;
    end
  end

  p_sk_in_frame_r4: assert property (@(posedge clk) disable iff (rst)
    mw_sk |-> mw_cs);
  p_di_hold_r4: assert property (@(posedge clk) disable iff (rst)
    mw_sk |-> $stable(mw_di));
  p_cs_gap_r6: assert property (@(posedge clk) disable iff (rst)
    (seen_hi_q && $rose(mw_cs)) |-> (cs_lo_cnt >= LCW'(CS_LOW_MIN)));
  p_poll_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (st == S_POLL) |-> (!mw_sk && mw_cs));
  p_err_release_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> !mw_cs);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/tb_mw_eeprom_host.sv
module tb_mw_eeprom_host;
  localparam int AW   = 6;
  localparam int DW   = 16;
  localparam int LW   = 3;
  localparam int SKH  = 2;
  localparam int GAPN = 3;
  localparam int PMAX = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic [LW-1:0] cmd_len = '0;
  logic          busy, done, err, rd_valid, mw_cs, mw_sk, mw_di;
  logic [DW-1:0] rd_data;
  logic          m_do = 1'b0;

  always #2 clk = ~clk;

  mw_eeprom_host #(
    .ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .SK_HALF(SKH),
    .CS_LOW_MIN(GAPN), .POLL_MAX(PMAX)
  ) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_len(cmd_len),
    .busy(busy), .done(done), .err(err), .rd_valid(rd_valid), .rd_data(rd_data),
    .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di), .mw_do(m_do)
  );

  // ---------------- behavioural memory model ----------------
  logic [DW-1:0] mem [64];
  logic        m_en = 1'b0, st_pend = 1'b0, sk_p = 1'b0, cs_p = 1'b0;
  int          m_busy = 0, m_busy_len = 20, m_mode = 0, m_n = 0, m_pend = 0;
  int          m_ra = 0, m_rb = 0, m_hiz = 0;
  logic [31:0] m_sr = '0;
  logic [AW-1:0] m_pa = '0;
  logic [DW-1:0] m_pd = '0;

  initial for (int i = 0; i < 64; i++) mem[i] = 16'(i * 257);

  always @(negedge clk) begin
    if (m_busy > 0) m_busy = m_busy - 1;
    if (cs_p && !mw_cs) begin
      if (m_pend != 0) begin
        st_pend = 1'b1;
        if (m_en) begin
          m_busy = m_busy_len;
          case (m_pend)
            1: mem[m_pa] = m_pd;
            2: mem[m_pa] = 16'hFFFF;
            3: for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
            default: for (int i = 0; i < 64; i++) mem[i] = m_pd;
          endcase
        end
      end
      m_pend = 0; m_mode = 0; m_do = 1'b0;
    end else if (!cs_p && mw_cs) begin
      m_mode = st_pend ? 3 : 0;
      m_n = 0; m_sr = '0;
    end
    if (mw_cs && m_mode == 3) m_do = (m_busy == 0);
    if (mw_cs && mw_sk && !sk_p) begin
      case (m_mode)
        0: if (mw_di) begin m_mode = 1; m_n = 0; m_sr = '0; end
        1: begin
          m_sr = {m_sr[30:0], mw_di};
          m_n  = m_n + 1;
          if (m_n == 2 + AW) begin
            case (m_sr[7:6])
              2'b10: begin m_mode = 2; m_ra = int'(m_sr[5:0]); m_rb = 16; m_do = 1'b0; end
              2'b11: begin m_pend = 2; m_pa = m_sr[5:0]; m_mode = 4; end
              2'b00: case (m_sr[5:4])
                       2'b11: begin m_en = 1'b1; m_mode = 4; end
                       2'b00: begin m_en = 1'b0; m_mode = 4; end
                       2'b10: begin m_pend = 3; m_mode = 4; end
                       default: ;
                     endcase
              default: ;
            endcase
          end else if (m_n == 2 + AW + 16) begin
            m_pd = m_sr[15:0];
            m_pa = m_sr[21:16];
            m_pend = (m_sr[23:22] == 2'b01) ? 1 : 4;
            m_mode = 4;
          end
        end
        2: begin
          if (m_rb == 0) begin m_ra = (m_ra + 1) % 64; m_rb = 16; end
          m_rb = m_rb - 1;
          m_do = mem[m_ra][m_rb];
        end
        3: if (mw_di) begin st_pend = 1'b0; m_mode = 4; m_do = 1'b0; m_hiz++; end
        default: ;
      endcase
    end
    sk_p = mw_sk;
    cs_p = mw_cs;
  end

  // ---------------- monitors ----------------
  int n_run = 0, n_fail = 0, cyc = 0;
  bit wd_fired = 1'b0;
  logic [DW-1:0] rd_buf [64];
  int rd_cnt = 0, done_cnt = 0, done_run = 0, done_bad = 0;
  int sk_hi = 0, sk_lo = 0, sk_bad = 0, di_bad = 0, cs_lo = 0, gap_bad = 0;
  logic di_p = 1'b0, skm_p = 1'b0, csm_p = 1'b0, seen_hi = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) wd_fired = 1'b1;
    if (!rst) begin
      if (rd_valid) begin rd_buf[rd_cnt % 64] = rd_data; rd_cnt++; end
      if (done) begin done_cnt++; done_run++; if (done_run > 1) done_bad++; end
      else done_run = 0;
      if (mw_sk) begin
        sk_hi++;
        if (mw_di !== di_p && skm_p) di_bad++;
        if (!mw_cs) sk_bad++;
      end
      if (!mw_sk && skm_p) begin if (sk_hi != SKH) sk_bad++; sk_hi = 0; end
      if (mw_sk && !skm_p && mw_cs && csm_p && sk_lo < SKH) sk_bad++;
      if (mw_sk) sk_lo = 0; else sk_lo++;
      if (mw_cs && !csm_p && seen_hi && cs_lo < GAPN) gap_bad++;
      if (mw_cs) begin seen_hi = 1'b1; cs_lo = 0; end else cs_lo++;
      di_p = mw_di; skm_p = mw_sk; csm_p = mw_cs;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done();
    while (!done && !wd_fired) @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [LW-1:0] l);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_len = l; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
  endtask

  // {op, addr, wdata, expected first read word}
  localparam logic [40:0] VEC [15] = '{
    {3'd3, 6'd0,  16'h0000, 16'h0000},
    {3'd1, 6'd5,  16'h1234, 16'h0000},
    {3'd0, 6'd5,  16'h0000, 16'h1234},
    {3'd1, 6'd63, 16'hBEEF, 16'h0000},
    {3'd0, 6'd63, 16'h0000, 16'hBEEF},
    {3'd2, 6'd5,  16'h0000, 16'h0000},
    {3'd0, 6'd5,  16'h0000, 16'hFFFF},
    {3'd4, 6'd0,  16'h0000, 16'h0000},
    {3'd1, 6'd5,  16'h0000, 16'h0000},
    {3'd0, 6'd5,  16'h0000, 16'hFFFF},
    {3'd3, 6'd0,  16'h0000, 16'h0000},
    {3'd6, 6'd0,  16'hA5A5, 16'h0000},
    {3'd0, 6'd17, 16'h0000, 16'hA5A5},
    {3'd5, 6'd0,  16'h0000, 16'h0000},
    {3'd0, 6'd40, 16'h0000, 16'hFFFF}
  };

  initial begin
    repeat (4) @(negedge clk);
    chk(!mw_cs && !mw_sk && !mw_di && !busy && !done && !err && !rd_valid,
        "R1 outputs in reset", {25'd0, mw_cs, mw_sk, mw_di, busy, done, err, rd_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!mw_cs && !mw_sk && !busy && !done && !err,
        "R1 outputs after reset", {27'd0, mw_cs, mw_sk, busy, done, err}, 0);

    // R2 / R3 / R7: table walk
    for (int i = 0; i < 15; i++) begin
      int base;
      base = rd_cnt;
      issue(VEC[i][40:38], VEC[i][37:32], VEC[i][31:16], '0);
      if (VEC[i][40:38] == 3'd0) begin
        @(negedge clk);
        chk(rd_cnt == base + 1, "R5 single word count", rd_cnt - base, 1);
        chk(rd_buf[base % 64] == VEC[i][15:0], (i < 7) ? "R2 read-back" : "R3 read-back",
            rd_buf[base % 64], VEC[i][15:0]);
      end else if (VEC[i][40:38] inside {3'd1, 3'd2, 3'd5, 3'd6}) begin
        chk(!err, "R7 poll ended ready", err, 0);
      end
    end
    chk(m_hiz == 6, "R7 release bit after each poll", m_hiz, 6);

    // R5: burst of four words wrapping past the top address
    issue(3'd1, 6'd62, 16'h1111, '0);
    issue(3'd1, 6'd63, 16'h2222, '0);
    issue(3'd1, 6'd0,  16'h3333, '0);
    begin
      int base;
      base = rd_cnt;
      issue(3'd0, 6'd62, '0, 3'd3);
      @(negedge clk);
      chk(rd_cnt == base + 4, "R5 burst word count", rd_cnt - base, 4);
      chk(rd_buf[base % 64] == 16'h1111, "R5 burst word 0", rd_buf[base % 64], 16'h1111);
      chk(rd_buf[(base + 1) % 64] == 16'h2222, "R5 burst word 1", rd_buf[(base + 1) % 64], 16'h2222);
      chk(rd_buf[(base + 2) % 64] == 16'h3333, "R5 burst word 2", rd_buf[(base + 2) % 64], 16'h3333);
      chk(rd_buf[(base + 3) % 64] == 16'hFFFF, "R5 burst word 3", rd_buf[(base + 3) % 64], 16'hFFFF);
    end

    // R9: strobe while busy is ignored
    begin
      int dbase;
      @(negedge clk);
      cmd_op = 3'd1; cmd_addr = 6'd7; cmd_wdata = 16'hAAAA; cmd_len = '0; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      dbase = done_cnt;
      repeat (10) @(negedge clk);
      chk(busy, "R9 busy during frame", busy, 1);
      cmd_wdata = 16'h5555; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_done();
      repeat (200) @(negedge clk);
      chk(done_cnt == dbase + 1 && !busy, "R9 single completion", done_cnt - dbase, 1);
      begin
        int base;
        base = rd_cnt;
        issue(3'd0, 6'd7, '0, '0);
        @(negedge clk);
        chk(rd_buf[base % 64] == 16'hAAAA, "R9 second strobe had no effect", rd_buf[base % 64], 16'hAAAA);
      end
    end

    // R10: start strobe in the done cycle
    begin
      int base;
      issue(3'd1, 6'd9, 16'h7777, '0);
      chk(done && !busy, "R10 busy low with done", {done, busy}, 2'b10);
      cmd_op = 3'd0; cmd_addr = 6'd9; cmd_len = '0; cmd_valid = 1'b1;
      base = rd_cnt;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(busy && !done, "R10 strobe in done cycle accepted", {busy, done}, 2'b10);
      wait_done();
      @(negedge clk);
      chk(rd_cnt == base + 1 && rd_buf[base % 64] == 16'h7777, "R10 back-to-back read",
          rd_buf[base % 64], 16'h7777);
    end

    // R8: memory never turns ready
    @(posedge clk);
    m_busy_len = 100000;
    issue(3'd1, 6'd8, 16'h0001, '0);
    chk(err, "R8 timeout flag", err, 1);
    chk(!mw_cs, "R8 chip select released", mw_cs, 0);
    repeat (5) @(negedge clk);
    chk(err, "R8 flag held while idle", err, 1);
    @(posedge clk);
    m_busy = 0; st_pend = 1'b0; m_mode = 0; m_busy_len = 20;
    issue(3'd3, 6'd0, '0, '0);
    chk(!err, "R8 flag cleared by next command", err, 0);

    chk(sk_bad == 0, "R4 clock half periods", sk_bad, 0);
    chk(di_bad == 0, "R4 data stable while clock high", di_bad, 0);
    chk(gap_bad == 0, "R6 chip select low time", gap_bad, 0);
    chk(done_bad == 0, "R10 done one cycle wide", done_bad, 0);

    if (wd_fired) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule